// File: doc/BRIEF.md
# Multi-Channel Edge Capture Unit

The unit timestamps external events on four input pins. Each pin is brought into the clock domain through a short synchronizer chain. A per-channel edge mode then decides which transitions count. On a qualifying transition the channel stores the value of one of several free-running counters in its 16-bit capture register, sets a capture flag and records whether the transition was rising or falling. The counters are produced elsewhere and arrive as one concatenated input bus. A channel may raise its interrupt line when its flag is set and its interrupt enable is on.

Software works the unit through a small word-wide register port. Writes take effect on the clock edge. Reads come back combinationally from the address. The four channels are configured in pairs: one control word serves channels 0 and 1, and another serves channels 2 and 3. One word selects the counter source for every channel. A read-only word holds the edge polarities, and four read-only words hold the capture values.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, every register address (0 to 7) reads 0 and every interrupt line is low.
- R2: Each channel's 2-bit edge mode uses these codes: 00 off, 01 rising only, 10 falling only, 11 both edges. The mode sits at control bits [1:0] for the even channel of a pair and at bits [3:2] for the odd channel.
- R3: While a channel's mode is off, an input transition changes neither its capture register, its flag nor its polarity bit.
- R4: A qualifying transition on a pin loads the selected counter value into that channel's capture word and sets its flag. The flag is control bit 6 for the even channel and bit 7 for the odd channel. Both are visible after the fourth rising clock edge that follows the pin change.
- R5: The source word at address 2 holds a 2-bit counter index for channel c at bits [2c+1:2c]. Index n picks counter bits [16n+15:16n].
- R6: Status word bit c at address 3 reads 1 when channel c's last capture came from a rising edge and 0 when it came from a falling edge. The bit changes only when a capture occurs.
- R7: Interrupt line c is high exactly when channel c's flag and its interrupt enable are both 1. The enable is control bit 4 for the even channel and bit 5 for the odd channel.
- R8: Writing 0 to a flag bit clears the flag. Writing 1 leaves it unchanged.
- R9: A capture in the same cycle as a flag-clearing write leaves the flag set.
- R10: Capture values are read as whole 16-bit words at address 4+c. Writes to the status word and to the capture words change nothing.
- R11: The control word at address 0 serves channels 0 and 1, and the word at address 1 serves channels 2 and 3. A write to one word leaves the other pair's configuration untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside |
| cap_pin_i | input | 4 | Asynchronous event pins, one per channel |
| counters_i | input | 64 | Free-running counter values, counter n at bits [16n+15:16n] |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 16 | Register write data |
| bus_rdata_o | output | 16 | Register read data for bus_addr_i |
| irq_o | output | 4 | Per-channel interrupt requests |

## Verification
A stuck or mis-decoded edge mode appears as a capture word that keeps its old value, or as a flag that fails to rise, four clock edges after a pin change. A wrong counter index appears as a capture word holding another counter's pattern, in that same read. Flag-update ordering errors between a clear and a capture show up within one cycle as a flag read back as 0, or as an interrupt line that stays high or low against its enable. Cross-talk between the two control words shows up in the first readback of the other pair's word.

// File: rtl/ecu_pkg.sv
package ecu_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  localparam int unsigned NUM_CH = 4;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADR_CTRL_LO = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_CTRL_HI = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_SRC     = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_STAT    = 3'd3;

endpackage

// File: rtl/ecu_edge_detect.sv
module ecu_edge_detect
  import ecu_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  edge_mode_e mode_i,
  output logic       hit_o,
  output logic       rise_o
);

  // chain_q[SYNC_STAGES-1] is the synchronized level; the last flop keeps history
  logic [SYNC_STAGES:0] chain_q, chain_d;
  logic                 synced, prev;
  logic                 rise_det, fall_det;
  logic                 hit_d;

  always_comb begin
    chain_d = {chain_q[SYNC_STAGES-1:0], pin_i};
  end

  assign synced   = chain_q[SYNC_STAGES-1];
  assign prev     = chain_q[SYNC_STAGES];
  assign rise_det = synced & ~prev;
  assign fall_det = ~synced & prev;

  always_comb begin
    case (mode_i)
      EDGE_RISE: hit_d = rise_det;
      EDGE_FALL: hit_d = fall_det;
      EDGE_BOTH: hit_d = rise_det | fall_det;
      default:   hit_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      hit_o   <= 1'b0;
      rise_o  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      hit_o   <= hit_d;
      rise_o  <= rise_det;
    end
  end

  AST_OFF_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == EDGE_OFF) |=> !hit_o); // R3

  AST_HIT_NEEDS_TRANSITION: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> $past(synced) != $past(prev)); // R4

endmodule

// File: rtl/ecu_src_mux.sv
module ecu_src_mux #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_SRC = 4,
  parameter int unsigned SEL_W   = 2
) (
  input  logic [NUM_SRC*CNT_W-1:0] counters_i,
  input  logic [SEL_W-1:0]         sel_i,
  output logic [CNT_W-1:0]         value_o
);

  always_comb begin
    value_o = '0;
    for (int n = 0; n < int'(NUM_SRC); n++) begin
      if (int'(sel_i) == n) begin
        value_o = counters_i[n*CNT_W +: CNT_W];
      end
    end
  end

endmodule

// File: rtl/ecu_channel.sv
module ecu_channel
  import ecu_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit_i,
  input  logic             rise_i,
  input  edge_mode_e       mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cap_o,
  output logic             flag_o,
  output logic             pol_o
);

  logic             capture;
  logic [CNT_W-1:0] cap_q, cap_d;
  logic             flag_q, flag_d;
  logic             pol_q, pol_d;

  // a pending hit is dropped if the channel was switched off meanwhile
  assign capture = hit_i & (mode_i != EDGE_OFF);

  always_comb begin
    cap_d  = cap_q;
    pol_d  = pol_q;
    flag_d = flag_q & ~clr_i;
    if (capture) begin
      cap_d  = cnt_i;
      pol_d  = rise_i;
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
      pol_q  <= 1'b0;
    end else begin
      cap_q  <= cap_d;
      flag_q <= flag_d;
      pol_q  <= pol_d;
    end
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;
  assign pol_o  = pol_q;

  AST_OFF_KEEPS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == EDGE_OFF) |=> ($stable(cap_q) && $stable(pol_q))); // R3

  AST_CAPTURE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> flag_q); // R4

  AST_FLAG_ONLY_FROM_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(capture)); // R4

  AST_POL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(pol_q)); // R6

  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !capture) |=> !flag_q); // R8

  AST_CAPTURE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && capture) |=> flag_q); // R9

endmodule

// File: rtl/ecu_regs.sv
module ecu_regs
  import ecu_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SEL_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic [NUM_CH-1:0]       flag_i,
  input  logic [NUM_CH-1:0]       pol_i,
  input  logic [NUM_CH*CNT_W-1:0] cap_i,
  output edge_mode_e              mode_o [NUM_CH],
  output logic [NUM_CH-1:0]       ie_o,
  output logic [NUM_CH-1:0]       clr_o,
  output logic [NUM_CH*SEL_W-1:0] sel_o,
  output logic [DATA_W-1:0]       rd_data_o
);

  localparam int unsigned SRC_BITS = NUM_CH * SEL_W;

  edge_mode_e                mode_q [NUM_CH];
  edge_mode_e                mode_d [NUM_CH];
  logic [NUM_CH-1:0]         ie_q, ie_d;
  logic [SRC_BITS-1:0]       sel_q, sel_d;
  logic                      is_ctrl;
  logic                      unused_wr_hi;

  assign is_ctrl      = (addr_i == ADR_CTRL_LO) || (addr_i == ADR_CTRL_HI);
  assign unused_wr_hi = ^wr_data_i[DATA_W-1:8];

  // next state of the writable fields
  always_comb begin
    mode_d = mode_q;
    ie_d   = ie_q;
    sel_d  = sel_q;
    clr_o  = '0;
    if (wr_en_i) begin
      if (is_ctrl) begin
        for (int k = 0; k < 2; k++) begin
          mode_d[{addr_i[0], k[0]}] = edge_mode_e'(wr_data_i[2*k +: 2]);
          ie_d[{addr_i[0], k[0]}]   = wr_data_i[4+k];
          clr_o[{addr_i[0], k[0]}]  = ~wr_data_i[6+k];
        end
      end else if (addr_i == ADR_SRC) begin
        sel_d = wr_data_i[SRC_BITS-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < int'(NUM_CH); c++) begin
        mode_q[c] <= EDGE_OFF;
      end
      ie_q  <= '0;
      sel_q <= '0;
    end else begin
      for (int c = 0; c < int'(NUM_CH); c++) begin
        mode_q[c] <= mode_d[c];
      end
      ie_q  <= ie_d;
      sel_q <= sel_d;
    end
  end

  // read path
  always_comb begin
    rd_data_o = '0;
    if (is_ctrl) begin
      rd_data_o[7:0] = {flag_i[{addr_i[0], 1'b1}], flag_i[{addr_i[0], 1'b0}],
                        ie_q[{addr_i[0], 1'b1}],   ie_q[{addr_i[0], 1'b0}],
                        mode_q[{addr_i[0], 1'b1}], mode_q[{addr_i[0], 1'b0}]};
    end else if (addr_i == ADR_SRC) begin
      rd_data_o[SRC_BITS-1:0] = sel_q;
    end else if (addr_i == ADR_STAT) begin
      rd_data_o[NUM_CH-1:0] = pol_i;
    end else begin
      rd_data_o[CNT_W-1:0] = cap_i[int'(addr_i[1:0])*CNT_W +: CNT_W];
    end
  end

  assign mode_o = mode_q;
  assign ie_o   = ie_q;
  assign sel_o  = sel_q;

  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i >= ADR_STAT) |=> ($stable(ie_q) && $stable(sel_q))); // R10

  AST_PAIR_ISOLATION: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == ADR_CTRL_HI) |=>
      ($stable(mode_q[0]) && $stable(mode_q[1]) && $stable(ie_q[1:0]))); // R11

endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
  import ecu_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned NUM_SRC     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DATA_W      = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        cap_pin_i,
  input  logic [NUM_SRC*CNT_W-1:0] counters_i,
  input  logic                     bus_wr_i,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic [DATA_W-1:0]        bus_wdata_i,
  output logic [DATA_W-1:0]        bus_rdata_o,
  output logic [NUM_CH-1:0]        irq_o
);

  localparam int unsigned SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [1:0]              rst_pipe_q;
  logic                    rst_sync_n;
  edge_mode_e              mode [NUM_CH];
  logic [NUM_CH-1:0]       ie, clr, flag, pol, hit, rise;
  logic [NUM_CH*SEL_W-1:0] sel;
  logic [NUM_CH*CNT_W-1:0] cap_all;
  logic [NUM_CH*CNT_W-1:0] src_val;

  // reset asserts at once, releases two clocks later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  ecu_regs #(
    .DATA_W(DATA_W),
    .CNT_W (CNT_W),
    .SEL_W (SEL_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en_i  (bus_wr_i),
    .addr_i   (bus_addr_i),
    .wr_data_i(bus_wdata_i),
    .flag_i   (flag),
    .pol_i    (pol),
    .cap_i    (cap_all),
    .mode_o   (mode),
    .ie_o     (ie),
    .clr_o    (clr),
    .sel_o    (sel),
    .rd_data_o(bus_rdata_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ecu_edge_detect #(
      .SYNC_STAGES(SYNC_STAGES)
    ) u_edge (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .pin_i (cap_pin_i[c]),
      .mode_i(mode[c]),
      .hit_o (hit[c]),
      .rise_o(rise[c])
    );

    ecu_src_mux #(
      .CNT_W  (CNT_W),
      .NUM_SRC(NUM_SRC),
      .SEL_W  (SEL_W)
    ) u_mux (
      .counters_i(counters_i),
      .sel_i     (sel[c*SEL_W +: SEL_W]),
      .value_o   (src_val[c*CNT_W +: CNT_W])
    );

    ecu_channel #(
      .CNT_W(CNT_W)
    ) u_chan (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .hit_i (hit[c]),
      .rise_i(rise[c]),
      .mode_i(mode[c]),
      .cnt_i (src_val[c*CNT_W +: CNT_W]),
      .clr_i (clr[c]),
      .cap_o (cap_all[c*CNT_W +: CNT_W]),
      .flag_o(flag[c]),
      .pol_o (pol[c])
    );
  end

  assign irq_o = flag & ie;

  AST_IRQ_QUIET_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flag == '0) |-> (irq_o == '0)); // R7

endmodule

// File: tb/test_edge_capture_unit.sv
`timescale 1ns/1ps
module test_edge_capture_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  pins;
  logic [63:0] cnt;
  logic        wr;
  logic [2:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic [3:0]  irq;

  int checks = 0;
  int errors = 0;

  logic [1:0] sh_mode [4];
  logic [3:0] sh_ie;
  logic [7:0] sh_src;

  always #2 clk = ~clk;

  edge_capture_unit i_edge_capture_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_pin_i  (pins),
    .counters_i (cnt),
    .bus_wr_i   (wr),
    .bus_addr_i (addr),
    .bus_wdata_i(wdata),
    .bus_rdata_o(rdata),
    .irq_o      (irq)
  );

  // {channel[1:0], mode[1:0], source[1:0], start level, end level, capture expected}
  localparam logic [8:0] VEC [10] = '{
    {2'd0, 2'b01, 2'd0, 1'b0, 1'b1, 1'b1},
    {2'd0, 2'b01, 2'd1, 1'b1, 1'b0, 1'b0},
    {2'd1, 2'b10, 2'd2, 1'b1, 1'b0, 1'b1},
    {2'd1, 2'b10, 2'd3, 1'b0, 1'b1, 1'b0},
    {2'd2, 2'b11, 2'd3, 1'b0, 1'b1, 1'b1},
    {2'd2, 2'b11, 2'd0, 1'b1, 1'b0, 1'b1},
    {2'd3, 2'b00, 2'd1, 1'b0, 1'b1, 1'b0},
    {2'd3, 2'b01, 2'd2, 1'b0, 1'b1, 1'b1},
    {2'd0, 2'b11, 2'd2, 1'b1, 1'b0, 1'b1},
    {2'd3, 2'b10, 2'd0, 1'b1, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1;
    d = rdata;
  endtask

  // keep[k]=1 writes 1 to that flag (no change), 0 clears it
  task automatic wr_ctrl(input int pair, input logic [1:0] keep);
    bus_wr(3'(pair), {8'h00, keep, sh_ie[2*pair+1], sh_ie[2*pair],
                      sh_mode[2*pair+1], sh_mode[2*pair]});
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int unsigned wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] rv, old_cap, old_stat, exp_cap;
    rst_n = 1'b0; pins = '0; cnt = '0; wr = 1'b0; addr = '0; wdata = '0;
    for (int c = 0; c < 4; c++) sh_mode[c] = 2'b00;
    sh_ie = '0; sh_src = '0;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);

    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      bus_rd(3'(a), rv);
      chk($sformatf("R1 reset read addr %0d", a), rv, 16'h0000);
    end
    chk("R1 reset irq", {12'h0, irq}, 16'h0000);

    // table-driven edge modes, sources and polarity (R2 R3 R4 R5 R6 R10)
    for (int v = 0; v < 10; v++) begin
      logic [8:0] vec;
      int ch, pr;
      logic [1:0] md, src;
      logic from_l, to_l, hit;
      vec = VEC[v];
      ch = int'(vec[8:7]); md = vec[6:5]; src = vec[4:3];
      from_l = vec[2]; to_l = vec[1]; hit = vec[0];
      pr = ch / 2;

      sh_mode[ch] = 2'b00;
      wr_ctrl(pr, 2'b11);
      @(negedge clk); pins[ch] = from_l;
      wait_cyc(6);
      wr_ctrl(pr, (ch % 2 == 1) ? 2'b01 : 2'b10);
      bus_rd(3'(4 + ch), old_cap);
      bus_rd(3'd3, old_stat);

      sh_src[2*ch +: 2] = src;
      bus_wr(3'd2, {8'h00, sh_src});
      for (int j = 0; j < 4; j++) cnt[j*16 +: 16] = {4'(j + 1), 4'h5, 8'(v)};
      sh_mode[ch] = md;
      wr_ctrl(pr, 2'b11);
      @(negedge clk); pins[ch] = to_l;
      wait_cyc(6);

      exp_cap = hit ? cnt[int'(src)*16 +: 16] : old_cap;
      bus_rd(3'(pr), rv);
      chk($sformatf("R2 R3 R4 vec %0d flag", v), {15'h0, rv[6 + ch % 2]}, {15'h0, hit});
      bus_rd(3'(4 + ch), rv);
      chk($sformatf("R4 R5 R10 vec %0d capture word", v), rv, exp_cap);
      bus_rd(3'd3, rv);
      chk($sformatf("R6 vec %0d polarity", v), {15'h0, rv[ch]},
          {15'h0, hit ? to_l : old_stat[ch]});
    end

    // R7 R8: interrupt gating and flag write semantics on channel 0
    sh_mode[0] = 2'b01; sh_ie[0] = 1'b1;
    wr_ctrl(0, 2'b10);
    chk("R7 irq low with flag clear", {15'h0, irq[0]}, 16'h0000);
    @(negedge clk); pins[0] = 1'b1;
    wait_cyc(6);
    chk("R7 irq high with flag and enable", {15'h0, irq[0]}, 16'h0001);
    wr_ctrl(0, 2'b11);
    bus_rd(3'd0, rv);
    chk("R8 writing 1 keeps flag", {15'h0, rv[6]}, 16'h0001);
    sh_ie[0] = 1'b0;
    wr_ctrl(0, 2'b11);
    chk("R7 irq low with enable off", {15'h0, irq[0]}, 16'h0000);
    wr_ctrl(0, 2'b10);
    bus_rd(3'd0, rv);
    chk("R8 writing 0 clears flag", {15'h0, rv[6]}, 16'h0000);

    // R9: clear write lands in the capture cycle
    @(negedge clk); pins[0] = 1'b0;
    wait_cyc(6);
    @(negedge clk); pins[0] = 1'b1;
    wait_cyc(3);
    wr = 1'b1; addr = 3'd0;
    wdata = {8'h00, 2'b10, sh_ie[1], sh_ie[0], sh_mode[1], sh_mode[0]};
    @(negedge clk); wr = 1'b0;
    bus_rd(3'd0, rv);
    chk("R9 capture beats clear", {15'h0, rv[6]}, 16'h0001);

    // R10: writes to read-only words are ignored
    bus_rd(3'd3, old_stat);
    bus_rd(3'd4, old_cap);
    bus_wr(3'd3, 16'hFFFF);
    bus_wr(3'd4, 16'h1234);
    bus_rd(3'd3, rv);
    chk("R10 status write ignored", rv, old_stat);
    bus_rd(3'd4, rv);
    chk("R10 capture write ignored", rv, old_cap);

    // R11: pair isolation
    bus_rd(3'd0, old_cap);
    sh_mode[2] = 2'b11;
    wr_ctrl(1, 2'b11);
    bus_rd(3'd0, rv);
    chk("R11 low pair untouched", rv, old_cap);
    bus_rd(3'd1, rv);
    chk("R11 high pair written", {12'h0, rv[3:0]}, {12'h0, sh_mode[3], sh_mode[2]});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule